// File: doc/BRIEF.md
# DVMA Page Table Walker

This block turns a 32-bit device virtual address into a 36-bit physical address by reading one page table entry from memory for every request. There is no translation cache. Each lookup costs one memory read plus a fixed two cycles of internal processing. Pages are 4 KB, so the low twelve address bits pass through unchanged. The entry supplies the upper 24 bits of the physical address.

A requester offers an address and a read/write flag on a valid/ready channel. The walker accepts one request at a time and records the table base from the register file at that moment. It then issues a read of the entry and waits for the data. When the entry is not valid, or a write hits a read-only page, the walker answers with a fault. In the same cycle it pulses a capture strobe, so the register file sees fresh error-status and fault-address values.

Top module: `dvma_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_rd_req, rsp_valid and flt_capture are 0. flt_status reads 0x00800000 and flt_addr reads 0.
- R2: While mem_rd_req is high, mem_rd_addr equals (base << 4) plus (va >> 10 with its two low bits cleared), truncated to 36 bits. base is tbl_base and va is req_addr, both as sampled at acceptance. Later changes of tbl_base have no effect.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high only while the walker is idle. mem_rd_req rises in the cycle after acceptance and stays high until a cycle in which mem_rd_rvalid is high.
- R4: When no fault occurs, rsp_pa[35:12] equals entry bits 31:8, rsp_pa[11:0] equals va[11:0], and rsp_fault is 0.
- R5: An entry whose bit 1 (valid) is 0 gives rsp_fault = 1 and rsp_pa = 0.
- R6: A write request gives a fault when entry bit 2 (writable) is 0. A read request to a valid entry with bit 2 at 0 completes without a fault.
- R7: On a fault, flt_status becomes 0xC0800000, with bit 18 also set when the request was a read. flt_capture is high in exactly the response cycle of a faulting request. flt_status and flt_addr change at no other time.
- R8: On a fault, flt_addr becomes the request address with its low 12 bits cleared.
- R9: Entry bit 7 (cacheable) and bit 0 (write-as-zero) do not change rsp_pa or rsp_fault.
- R10: rsp_valid is high for exactly one cycle: the second cycle after the cycle in which mem_rd_rvalid was high. req_ready is high again in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tbl_base | input | 32 | Page table base from the register file |
| mem_rd_req | output | 1 | Entry read outstanding |
| mem_rd_addr | output | 36 | Byte address of the entry |
| mem_rd_rvalid | input | 1 | Entry data returned this cycle |
| mem_rd_data | input | 32 | Returned page table entry |
| rsp_valid | output | 1 | Response cycle |
| rsp_pa | output | 36 | Translated physical address (zero on fault) |
| rsp_fault | output | 1 | Translation faulted |
| flt_capture | output | 1 | One-cycle strobe: fault registers updated |
| flt_status | output | 32 | Captured error status word |
| flt_addr | output | 32 | Captured page-aligned fault address |

## Verification
In this block the response and the fault capture fall in the same cycle. The strobe, the fault flag, the zeroed physical address and the refreshed status and address values must all appear in one response cycle. The bench provokes this with read and write requests to invalid entries and to read-only entries, including a write that is both invalid and read-only. In every clock cycle it checks that the strobe matches a faulting response. In each response cycle it compares status, address and flag against the values its model predicts. A fault-free response that follows a fault is checked to confirm that the previously captured status and address stay untouched.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

    localparam int VA_W       = 32;
    localparam int PA_W       = 36;
    localparam int PTE_W      = 32;
    localparam int BASE_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int BASE_SHIFT = PA_W - BASE_W;
    localparam int IDX_SHIFT  = PAGE_SHIFT - 2;
    localparam int PPN_LSB    = PTE_W - (PA_W - PAGE_SHIFT);

    localparam int PTE_VALID_BIT = 1;
    localparam int PTE_WRITE_BIT = 2;

    localparam logic [31:0] FSTAT_RESET = 32'h0080_0000;
    localparam logic [31:0] FSTAT_FAULT = 32'hC080_0000;
    localparam logic [31:0] FSTAT_READ  = 32'h0004_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_RESPOND
    } walk_state_e;

    typedef struct packed {
        logic [VA_W-1:0]   va;
        logic              is_write;
        logic [BASE_W-1:0] base;
    } walk_req_t;

    typedef struct packed {
        logic              fault;
        logic [PA_W-1:0]   pa;
        logic [31:0]       status;
        logic [VA_W-1:0]   page_addr;
    } walk_result_t;

    function automatic logic [PA_W-1:0] entry_address(
        input logic [BASE_W-1:0] base,
        input logic [VA_W-1:0]   va
    );
        logic [PA_W-1:0] tbl;
        logic [PA_W-1:0] idx;
        tbl = PA_W'(base) << BASE_SHIFT;
        idx = PA_W'(va >> IDX_SHIFT) & ~PA_W'(3);
        return tbl + idx;
    endfunction

endpackage

// File: rtl/dvma_entry_gen.sv
module dvma_entry_gen
    import dvma_pkg::*;
(
    input  walk_req_t       req,
    output logic [PA_W-1:0] ent_addr
);
    always_comb begin
        ent_addr = entry_address(req.base, req.va);
    end
endmodule

// File: rtl/dvma_pte_eval.sv
module dvma_pte_eval
    import dvma_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    input  logic [PTE_W-1:0] pte,
    output walk_result_t     res
);
    logic valid_ok;
    logic write_ok;

    always_comb begin
        valid_ok      = pte[PTE_VALID_BIT];
        write_ok      = pte[PTE_WRITE_BIT] || !is_write;
        res.fault     = !(valid_ok && write_ok);
        res.pa        = res.fault ? '0 : {pte[PTE_W-1:PPN_LSB], va[PAGE_SHIFT-1:0]};
        res.status    = FSTAT_FAULT | (is_write ? 32'h0 : FSTAT_READ);
        res.page_addr = {va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/dvma_fault_regs.sv
module dvma_fault_regs
    import dvma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [31:0]     status_in,
    input  logic [VA_W-1:0] addr_in,
    output logic [31:0]     status_q,
    output logic [VA_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= FSTAT_RESET;
            addr_q   <= '0;
        end else if (capture) begin
            status_q <= status_in;
            addr_q   <= addr_in;
        end
    end

    AST_FAR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        addr_q[PAGE_SHIFT-1:0] == '0); // R8
endmodule

// File: rtl/dvma_walker.sv
module dvma_walker
    import dvma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic             req_write,
    input  logic [31:0]      tbl_base,
    output logic             mem_rd_req,
    output logic [35:0]      mem_rd_addr,
    input  logic             mem_rd_rvalid,
    input  logic [31:0]      mem_rd_data,
    output logic             rsp_valid,
    output logic [35:0]      rsp_pa,
    output logic             rsp_fault,
    output logic             flt_capture,
    output logic [31:0]      flt_status,
    output logic [31:0]      flt_addr
);
    walk_state_e      state_q;
    walk_req_t        req_q;
    logic [PTE_W-1:0] pte_q;
    walk_result_t     eval_res;
    walk_result_t     res_q;
    logic [PA_W-1:0]  ent_addr;
    logic             cap_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            pte_q   <= '0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    req_q   <= '{va: req_addr, is_write: req_write, base: tbl_base};
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (mem_rd_rvalid) begin
                    pte_q   <= mem_rd_data;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    res_q   <= eval_res;
                    state_q <= ST_RESPOND;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    dvma_entry_gen u_entry (
        .req      (req_q),
        .ent_addr (ent_addr)
    );

    dvma_pte_eval u_eval (
        .va       (req_q.va),
        .is_write (req_q.is_write),
        .pte      (pte_q),
        .res      (eval_res)
    );

    assign cap_now = (state_q == ST_CHECK) && eval_res.fault;

    dvma_fault_regs u_fregs (
        .clk       (clk),
        .rst       (rst),
        .capture   (cap_now),
        .status_in (eval_res.status),
        .addr_in   (eval_res.page_addr),
        .status_q  (flt_status),
        .addr_q    (flt_addr)
    );

    assign req_ready   = (state_q == ST_IDLE);
    assign mem_rd_req  = (state_q == ST_FETCH);
    assign mem_rd_addr = ent_addr;
    assign rsp_valid   = (state_q == ST_RESPOND);
    assign rsp_pa      = res_q.pa;
    assign rsp_fault   = rsp_valid && res_q.fault;
    assign flt_capture = rsp_valid && res_q.fault;

    AST_READY_NOT_IN_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R3
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && !mem_rd_rvalid |=> mem_rd_req); // R3
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $past(mem_rd_req && mem_rd_rvalid, 2) |-> rsp_valid); // R10
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_pa == '0); // R5
    AST_FAULT_STATUS_SET: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> flt_status[31] && flt_status[30] && flt_status[23]); // R7
    AST_STATUS_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_status) |-> flt_capture); // R7
    AST_ADDR_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_addr) |-> flt_capture); // R8
endmodule

// File: tb/dvma_walker_tb.sv
module dvma_walker_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        req_write;
    logic [31:0] tbl_base;
    logic        mem_rd_req;
    logic [35:0] mem_rd_addr;
    logic        mem_rd_rvalid;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic [35:0] rsp_pa;
    logic        rsp_fault;
    logic        flt_capture;
    logic [31:0] flt_status;
    logic [31:0] flt_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_stat;
    logic [31:0] exp_far;

    always #10 clk = ~clk;

    dvma_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .tbl_base(tbl_base),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .flt_capture(flt_capture), .flt_status(flt_status), .flt_addr(flt_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // every-clock comparison: capture strobe against the model of a faulting response (R7)
    always @(negedge clk) begin
        if (!rst) chk(flt_capture == (rsp_valid && rsp_fault), "R7", "strobe vs fault rsp",
                      64'(flt_capture), 64'(rsp_valid && rsp_fault));
    end

    task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] base,
                        input logic [31:0] pte, input int lat);
        logic [35:0] e_ent;
        logic [35:0] e_pa;
        bit          e_flt;
        e_ent = (36'(base) << 4) + (36'(va >> 10) & ~36'd3);
        e_flt = !pte[1] || (wr && !pte[2]);
        e_pa  = e_flt ? 36'd0 : {pte[31:8], va[11:0]};
        @(negedge clk);
        chk(req_ready == 1'b1, "R3", "ready idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = va; req_write = wr; tbl_base = base;
        @(negedge clk);
        req_valid = 1'b0; tbl_base = ~base; req_addr = ~va;
        chk(req_ready == 1'b0, "R3", "ready busy", 64'(req_ready), 64'd0);
        chk(mem_rd_req == 1'b1, "R3", "fetch issued", 64'(mem_rd_req), 64'd1);
        chk(mem_rd_addr == e_ent, "R2", "entry address", 64'(mem_rd_addr), 64'(e_ent));
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(mem_rd_req == 1'b1, "R3", "fetch held", 64'(mem_rd_req), 64'd1);
            chk(mem_rd_addr == e_ent, "R2", "entry addr held", 64'(mem_rd_addr), 64'(e_ent));
        end
        mem_rd_rvalid = 1'b1; mem_rd_data = pte;
        @(negedge clk);
        mem_rd_rvalid = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
        chk(rsp_valid == 1'b0, "R10", "no early rsp", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        if (e_flt) begin
            exp_stat = 32'hC080_0000 | (wr ? 32'h0 : 32'h0004_0000);
            exp_far  = {va[31:12], 12'h000};
        end
        chk(rsp_valid == 1'b1, "R10", "rsp timing", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == e_flt, e_flt ? "R5" : "R4", "fault flag", 64'(rsp_fault), 64'(e_flt));
        chk(rsp_pa == e_pa, e_flt ? "R5" : "R4", "physical addr", 64'(rsp_pa), 64'(e_pa));
        chk(flt_capture == e_flt, "R7", "capture strobe", 64'(flt_capture), 64'(e_flt));
        chk(flt_status == exp_stat, "R7", "fault status", 64'(flt_status), 64'(exp_stat));
        chk(flt_addr == exp_far, "R8", "fault address", 64'(flt_addr), 64'(exp_far));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp one cycle", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R10", "ready back", 64'(req_ready), 64'd1);
        chk(flt_status == exp_stat, "R7", "status held", 64'(flt_status), 64'(exp_stat));
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        tbl_base = '0; mem_rd_rvalid = 1'b0; mem_rd_data = '0;
        exp_stat = 32'h0080_0000; exp_far = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(mem_rd_req == 1'b0, "R1", "reset fetch", 64'(mem_rd_req), 64'd0);
        chk(rsp_valid == 1'b0, "R1", "reset rsp", 64'(rsp_valid), 64'd0);
        chk(flt_status == 32'h0080_0000, "R1", "reset status", 64'(flt_status), 64'h0080_0000);
        chk(flt_addr == 32'h0, "R1", "reset addr", 64'(flt_addr), 64'd0);

        walk(32'h1234_5678, 1'b0, 32'h0010_0000, 32'hABCD_EF02, 0);   // R4 R6 read of read-only
        walk(32'hFF00_3ABC, 1'b1, 32'h0200_0400, 32'h0000_1106, 2);   // R4 writable write
        walk(32'h0000_5FFF, 1'b1, 32'h0000_0800, 32'h1234_5602, 1);   // R6 write to read-only
        walk(32'h8765_4321, 1'b0, 32'h0300_0000, 32'h5555_5504, 3);   // R5 read of invalid
        walk(32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_1006, 0);   // R7 status held after fault
        walk(32'hC0DE_0123, 1'b1, 32'h0400_0000, 32'h7777_7700, 7);   // R5 invalid + read-only write
        walk(32'h4444_4444, 1'b0, 32'h0000_1000, 32'h9999_9983, 1);   // R9 bits 7,0 set
        walk(32'h4444_4444, 1'b0, 32'h0000_1000, 32'h9999_9902, 1);   // R9 same without
        walk(32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF87, 4);   // R2 wrap, R9
        walk(32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF79, 0);   // R5 bit1 clear, R9

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule